// File: doc/BRIEF.md
# Gated Active-Video FIFO Writer

This block sits between a video timing interface and the write port of a clock-crossing FIFO. Each clock it sees one sample with a data-enable qualifier. Only samples inside the active picture are pushed. The FIFO full flag guards every push. Blanking samples are dropped.

Writing is gated per frame. A software go bit is captured when vertical sync falls, and that captured value holds for the whole frame. If a push meets a full FIFO, the block stops writing for the rest of the frame and raises a sticky overflow flag. It resumes at the next vertical sync falling edge, provided go is set there.

With packing built in, a per-line select input can mark the incoming video as sequential. The block then gathers successive colour-plane samples into one parallel word before writing it. When the select marks the video as already parallel, each enabled sample is written as it arrives.

Top module: `vfw_top`

## Requirements
- R1: A sample is written only in a cycle where `de_i` is 1; samples with `de_i` = 0 never produce a write.
- R2: In the cycle where `vsync_i` is 0 and was 1 in the previous cycle (a falling edge), the block captures `go_i`. Writing for the following frame is enabled only if that captured value is 1. A change of `go_i` at any other time has no effect until the next falling edge.
- R3: When a write is due and `fifo_full_i` is 1 in that cycle, the write is dropped (overflow). No further write happens in that frame, even after `fifo_full_i` returns to 0.
- R4: After an overflow, writing resumes from the next vertical sync falling edge at which `go_i` is 1.
- R5: With `seq_i` = 1, every second enabled sample completes one word. The first sample's bits [SAMPLE_W-1:0] go to word bits [SAMPLE_W-1:0], and the second sample's go to bits [2*SAMPLE_W-1:SAMPLE_W]. The bench uses SAMPLE_W = 8.
- R6: With `seq_i` = 0, every enabled sample is written unchanged as one word.
- R7: `ovf_o` goes to 1 in the cycle after an overflow. It stays at 1 until a cycle with `ovf_clr_i` = 1 and no new overflow; it is 0 after that cycle.
- R8: A partly gathered pixel is discarded when `de_i` drops to 0, when an overflow occurs, or when a frame starts. The next enabled sample is then taken as the first plane.
- R9: `wr_en_o` and `wr_data_o` are registered and reflect the sample of the previous clock. After reset, `wr_en_o` = 0, `ovf_o` = 0 and writing is disabled until a falling edge with `go_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | SAMPLE_W*PLANES | Pixel sample; in sequential mode only the low SAMPLE_W bits carry the plane |
| de_i | input | 1 | Active picture qualifier |
| vsync_i | input | 1 | Vertical sync; its falling edge starts a frame |
| go_i | input | 1 | Software enable, sampled at frame start |
| seq_i | input | 1 | 1 = planes arrive one after another, 0 = planes arrive in parallel |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| fifo_full_i | input | 1 | FIFO has no room for a word |
| wr_data_o | output | SAMPLE_W*PLANES | FIFO write data |
| wr_en_o | output | 1 | FIFO write strobe |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with SAMPLE_W = 8, PLANES = 2 and packing enabled. This gives 16-bit words. Every packing case is then reached with short lines: an odd sample count leaves a dangling half pixel, and a full FIFO can strike on the completing half of a pair. Because packing is enabled, both the parallel pass-through and the sequential paths exist in one build, and the select input can change from line to line.

// File: rtl/vfw_pkg.sv
package vfw_pkg;
  function automatic int unsigned vfw_idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vfw_frame_gate.sv
module vfw_frame_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  input  logic go_i,
  input  logic ovf_i,
  output logic frame_start_o,
  output logic write_ok_o
);
  logic vs_q;
  logic armed_q;
  logic halted_q;

  assign frame_start_o = vs_q & ~vsync_i;
  assign write_ok_o    = armed_q & ~halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q     <= 1'b0;
      armed_q  <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      vs_q <= vsync_i;
      if (frame_start_o) begin
        armed_q  <= go_i;
        halted_q <= 1'b0;
      end else if (ovf_i) begin
        halted_q <= 1'b1;
      end
    end
  end

  // R2: arm state only moves at frame start
  p_arm_at_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |=> $stable(armed_q));

  // R4: halt held until next frame start
  p_halt_until_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !frame_start_o) |=> halted_q);
endmodule

// File: rtl/vfw_plane_pack.sv
module vfw_plane_pack #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned PLANES   = 2,
  parameter bit          PACK_EN  = 1'b1,
  localparam int unsigned DATA_W  = SAMPLE_W * PLANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              de_i,
  input  logic              seq_i,
  input  logic              en_i,
  input  logic              clr_i,
  output logic              req_o,
  output logic [DATA_W-1:0] word_o
);
  import vfw_pkg::*;

  generate
    if (PACK_EN && PLANES > 1) begin : g_pack
      localparam int unsigned PH_W = vfw_idx_w(PLANES);
      localparam logic [PH_W-1:0] LAST = PH_W'(PLANES - 1);

      logic [PH_W-1:0]   phase_q;
      logic [DATA_W-1:0] hold_q;
      logic              take;

      assign take = en_i & de_i;

      always_comb begin
        req_o  = 1'b0;
        word_o = data_i;
        if (take) begin
          if (!seq_i) begin
            req_o = 1'b1;
          end else if (phase_q == LAST) begin
            req_o  = 1'b1;
            word_o = hold_q;
            word_o[(PLANES-1)*SAMPLE_W +: SAMPLE_W] = data_i[SAMPLE_W-1:0];
          end
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          phase_q <= '0;
          hold_q  <= '0;
        end else if (clr_i || !take || !seq_i || phase_q == LAST) begin
          phase_q <= '0;
        end else begin
          hold_q[phase_q*SAMPLE_W +: SAMPLE_W] <= data_i[SAMPLE_W-1:0];
          phase_q <= phase_q + 1'b1;
        end
      end

      // R5: plane index stays in range
      p_phase_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_q <= LAST);

      // R8: gap in data enable drops a partial pixel
      p_gap_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !de_i |=> phase_q == '0);
    end else begin : g_pass
      assign req_o  = en_i & de_i;
      assign word_o = data_i;
    end
  endgenerate
endmodule

// File: rtl/vfw_ovf_flag.sv
module vfw_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R7: flag is sticky without a clear
  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/vfw_top.sv
module vfw_top #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned PLANES   = 2,
  parameter bit          PACK_EN  = 1'b1,
  localparam int unsigned DATA_W  = SAMPLE_W * PLANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              de_i,
  input  logic              vsync_i,
  input  logic              go_i,
  input  logic              seq_i,
  input  logic              ovf_clr_i,
  input  logic              fifo_full_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_en_o,
  output logic              ovf_o
);
  logic              frame_start;
  logic              write_ok;
  logic              req;
  logic [DATA_W-1:0] word;
  logic              ovf_now;
  logic              push;

  assign ovf_now = req & fifo_full_i;
  assign push    = req & ~fifo_full_i;

  vfw_frame_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vsync_i       (vsync_i),
    .go_i          (go_i),
    .ovf_i         (ovf_now),
    .frame_start_o (frame_start),
    .write_ok_o    (write_ok)
  );

  vfw_plane_pack #(
    .SAMPLE_W (SAMPLE_W),
    .PLANES   (PLANES),
    .PACK_EN  (PACK_EN)
  ) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .de_i   (de_i),
    .seq_i  (seq_i),
    .en_i   (write_ok),
    .clr_i  (ovf_now | frame_start),
    .req_o  (req),
    .word_o (word)
  );

  vfw_ovf_flag u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_now),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= push;
      if (push) wr_data_o <= word;
    end
  end

  // R1: every write came from an enabled sample
  p_blank_never_written_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(de_i));

  // R3: no write issued against a full FIFO
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !$past(fifo_full_i));

  // R7: overflow raises the flag next cycle
  p_ovf_raise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && fifo_full_i) |=> ovf_o);
endmodule

// File: tb/sim_vfw_top.sv
module sim_vfw_top;
  localparam int SW = 8;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          de_i = 1'b0, vsync_i = 1'b0, go_i = 1'b0, seq_i = 1'b0;
  logic          ovf_clr_i = 1'b0, fifo_full_i = 1'b0;
  logic [DW-1:0] wr_data_o;
  logic          wr_en_o, ovf_o;

  always #10 clk_i = ~clk_i;

  vfw_top #(.SAMPLE_W(SW), .PLANES(2), .PACK_EN(1'b1)) u0 (
    .clk_i, .rst_ni, .data_i, .de_i, .vsync_i, .go_i, .seq_i,
    .ovf_clr_i, .fifo_full_i, .wr_data_o, .wr_en_o, .ovf_o
  );

  int checks = 0, fails = 0, words = 0;
  string cur_req = "R9";
  bit done = 1'b0;

  // behavioural reference
  bit m_vs, m_armed, m_halt, m_ovf, m_half, exp_en;
  int m_held;
  int exp_data;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_vs = 0; m_armed = 0; m_halt = 0; m_ovf = 0; m_half = 0;
      m_held = 0; exp_en = 0; exp_data = 0;
    end else begin
      bit fs, ok, want, over;
      int w;
      fs = m_vs && !vsync_i;
      ok = m_armed && !m_halt;
      want = 0; w = 0;
      if (ok && de_i) begin
        if (!seq_i) begin want = 1; w = int'(data_i); end
        else if (m_half) begin want = 1; w = int'(data_i[7:0]) * 256 + m_held; end
      end
      over = want && fifo_full_i;
      exp_en = want && !fifo_full_i;
      if (exp_en) exp_data = w;
      if (over) m_ovf = 1; else if (ovf_clr_i) m_ovf = 0;
      if (fs || over || !de_i || !ok || !seq_i || m_half) m_half = 0;
      else begin m_held = int'(data_i[7:0]); m_half = 1; end
      if (fs) begin m_armed = go_i; m_halt = 0; end
      else if (over) m_halt = 1;
      m_vs = vsync_i;
    end
  end

  task automatic compare();
    checks++;
    if (wr_en_o !== exp_en || ovf_o !== m_ovf ||
        (exp_en && int'(wr_data_o) != exp_data)) begin
      fails++;
      $display("FAIL %s: en=%b data=%h ovf=%b expected en=%b data=%h ovf=%b",
               cur_req, wr_en_o, wr_data_o, ovf_o, exp_en, exp_data[15:0], m_ovf);
    end
    if (wr_en_o === 1'b1) words++;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    de_i = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic frame_edge(bit go);
    go_i = go; vsync_i = 1; idle(3);
    vsync_i = 0; idle(2);
  endtask

  task automatic line(int n, bit seq, int base, int full_at);
    seq_i = seq;
    for (int i = 0; i < n; i++) begin
      de_i = 1; data_i = DW'(base + i * 17);
      fifo_full_i = (i == full_at);
      tick();
    end
    de_i = 0; fifo_full_i = 0; tick(); tick();
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk_i);
    cur_req = "R9";
    check("R9 reset en", int'(wr_en_o), 0);
    check("R9 reset ovf", int'(ovf_o), 0);
    rst_ni = 1; idle(2);
    line(4, 0, 16'h0100, -1);
    check("R9 no write before first go edge", words, 0);

    cur_req = "R2";
    frame_edge(0); go_i = 1;
    w0 = words; line(6, 0, 16'h0200, -1);
    check("R2 go raised mid-frame ignored", words - w0, 0);

    cur_req = "R6";
    frame_edge(1);
    w0 = words; line(6, 0, 16'hA1B2, -1);
    check("R6 one word per parallel sample", words - w0, 6);
    cur_req = "R1";
    w0 = words; idle(8);
    check("R1 blanking not written", words - w0, 0);

    cur_req = "R5";
    w0 = words; line(6, 1, 16'h0310, -1);
    check("R5 pairs packed", words - w0, 3);
    cur_req = "R8";
    w0 = words; line(7, 1, 16'h0420, -1);
    check("R8 odd sample dropped at line end", words - w0, 3);
    w0 = words; line(1, 1, 16'h0530, -1); line(1, 1, 16'h0540, -1);
    check("R8 halves across lines not joined", words - w0, 0);

    cur_req = "R2";
    go_i = 0;
    w0 = words; line(3, 0, 16'h0600, -1);
    check("R2 go dropped mid-frame ignored", words - w0, 3);

    cur_req = "R3";
    frame_edge(1);
    w0 = words; line(5, 0, 16'h0700, 2);
    check("R3 stop at full", words - w0, 2);
    check("R7 flag set", int'(ovf_o), 1);
    w0 = words; line(4, 0, 16'h0800, -1);
    check("R3 halted rest of frame", words - w0, 0);

    cur_req = "R4";
    frame_edge(1);
    w0 = words; line(4, 1, 16'h0900, 3);
    check("R4 resume then R8 full on second half", words - w0, 1);
    frame_edge(1);
    w0 = words; line(4, 0, 16'h0A00, -1);
    check("R4 resumed after overflow", words - w0, 4);
    cur_req = "R7";
    check("R7 flag still set", int'(ovf_o), 1);
    ovf_clr_i = 1; tick(); ovf_clr_i = 0; tick();
    check("R7 flag cleared", int'(ovf_o), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule